// File: doc/BRIEF.md
# Output-Compare Register Bank

This block keeps four 8-bit compare values and raises one equality flag per value whenever it equals the low byte of a free-running timer. Software-side data does not go straight into a compare register. It is first captured in an 8-bit staging accumulator, which reloads on every falling clock edge. A write strobe with a 2-bit slot index then copies the accumulator into one slot. Because of this, a write stores the data that was on the input one falling edge before the strobe.

All storage changes on the falling clock edge. The equality flags are pure combinational functions of the stored values and the timer byte. A surrounding timer unit uses the flags to time events when its counter passes a programmed value.

Top module: `ocmp_bank`

## Requirements
- R1: While `rst_n` is low and after it is released, the accumulator and all four slots read 00h until written.
- R2: The accumulator samples `wr_data` on every falling edge of `clk`. A write therefore stores the `wr_data` value present at the previous falling edge, not the value present at the falling edge of the write itself.
- R3: With `wr_en` high at a falling edge, only slot `wr_sel` (0 to 3) loads. Slot k occupies `cmp_val[8k+7:8k]`. The other three slots keep their values.
- R4: With `wr_en` low at a falling edge, no slot changes, whatever `wr_sel` and `wr_data` are doing.
- R5: A write replaces every bit of the selected slot with the accumulator value. No bit of the old contents survives.
- R6: `match[k]` is 1 exactly when slot k equals `tmr_lo`, and 0 otherwise. It follows `tmr_lo` with no clock delay.
- R7: Slots and the accumulator change only on falling edges of `clk`. A write set up before a rising edge is not yet visible after that rising edge.
- R8: A slot never written since reset drives its match flag high whenever `tmr_lo` is 00h, and low for any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 8 | Data sampled into the staging accumulator |
| wr_sel | input | 2 | Index of the slot to load |
| wr_en | input | 1 | Write strobe; copies the accumulator into slot `wr_sel` |
| tmr_lo | input | 8 | Low byte of the running timer |
| cmp_val | output | 32 | The four slot values, slot k in bits 8k+7:8k |
| match | output | 4 | Per-slot equality flag against `tmr_lo` |

## Verification
A data byte reaches a slot two falling edges after it is driven: one edge into the accumulator and one edge through the write. The bench drives inputs and samples outputs 2 ns after a falling edge, so each sample sees the state that edge left behind. The flags carry no delay, so the bench sets `tmr_lo` and samples 1 ns later without waiting for a clock. To confirm the falling-edge timing, the bench also samples 1 ns after the rising edge that sits between the write setup and its falling edge. At that point the slot must still hold its old value.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_SLOTS  = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ocmp_stage.sv
module ocmp_stage #(
  parameter int unsigned DATA_W = ocmp_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= din;
  end
endmodule

// File: rtl/ocmp_decode.sv
module ocmp_decode #(
  parameter int unsigned SLOTS = ocmp_pkg::DEF_SLOTS,
  parameter int unsigned SEL_W = ocmp_pkg::idx_width(SLOTS)
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [SLOTS-1:0] load
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_dec
    assign load[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/ocmp_slot.sv
module ocmp_slot #(
  parameter int unsigned DATA_W = ocmp_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] tmr,
  output logic [DATA_W-1:0] val,
  output logic              hit
);
  function automatic logic same_word(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b);
    return ~|(a ^ b);
  endfunction

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (load) val <= din;
  end

  assign hit = same_word(val, tmr);

  AST_SLOT_HOLDS: assert property (@(negedge clk) disable iff (!rst_n)
    !load |=> $stable(val)); // R4
  AST_SLOT_LOADS: assert property (@(negedge clk) disable iff (!rst_n)
    load |=> (val == $past(din))); // R5
endmodule

// File: rtl/ocmp_bank.sv
module ocmp_bank #(
  parameter int unsigned DATA_W = ocmp_pkg::DEF_DATA_W,
  parameter int unsigned SLOTS  = ocmp_pkg::DEF_SLOTS,
  localparam int unsigned SEL_W = ocmp_pkg::idx_width(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       tmr_lo,
  output logic [SLOTS*DATA_W-1:0] cmp_val,
  output logic [SLOTS-1:0]        match
);
  logic [DATA_W-1:0] acc_q;
  logic [SLOTS-1:0]  slot_load;

  ocmp_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .din(wr_data), .acc(acc_q)
  );

  ocmp_decode #(.SLOTS(SLOTS), .SEL_W(SEL_W)) u_dec (
    .en(wr_en), .sel(wr_sel), .load(slot_load)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [DATA_W-1:0] v;
    ocmp_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(slot_load[k]), .din(acc_q),
      .tmr(tmr_lo), .val(v), .hit(match[k])
    );
    assign cmp_val[k*DATA_W +: DATA_W] = v;
  end

  AST_ONE_SLOT: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(slot_load)); // R3
  AST_IDLE_FREEZE: assert property (@(negedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp_val)); // R4
  AST_ACC_SAMPLES: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> (acc_q == $past(wr_data))); // R2
  AST_WRITE_HITS: assert property (@(negedge clk) disable iff (!rst_n)
    wr_en |-> $countones(slot_load) == 1); // R3
endmodule

// File: tb/sim_ocmp_bank.sv
module sim_ocmp_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [1:0]  wr_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  tmr_lo = 8'h00;
  logic [31:0] cmp_val;
  logic [3:0]  match;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_slot [4];

  ocmp_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_sel(wr_sel),
    .wr_en(wr_en), .tmr_lo(tmr_lo), .cmp_val(cmp_val), .match(match)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  function automatic logic [31:0] pack_exp();
    return {exp_slot[3], exp_slot[2], exp_slot[1], exp_slot[0]};
  endfunction

  function automatic logic [3:0] exp_match(input logic [7:0] t);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[k] = (exp_slot[k] == t);
    return m;
  endfunction

  // write: present data, one edge into accumulator, one edge into slot
  task automatic do_write(input logic [1:0] s, input logic [7:0] d);
    wr_data = d;
    step();
    wr_en = 1'b1; wr_sel = s; wr_data = ~d;
    step();
    wr_en = 1'b0;
    exp_slot[s] = d;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) exp_slot[k] = 8'h00;
    #1;
    check("R1 slots in reset", cmp_val, 32'h0);
    wr_data = 8'h77;
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 slots after release", cmp_val, 32'h0);
    tmr_lo = 8'h00; #1;
    check("R8 untouched match at 00h", {28'h0, match}, 32'hF);
    tmr_lo = 8'h01; #1;
    check("R8 untouched no match at 01h", {28'h0, match}, 32'h0);
  endtask

  task automatic t_select();
    do_write(2'd2, 8'h5A);
    check("R3 only slot 2 loads", cmp_val, pack_exp());
    do_write(2'd0, 8'h11);
    do_write(2'd3, 8'hC3);
    do_write(2'd1, 8'h80);
    check("R3 all four slots", cmp_val, pack_exp());
  endtask

  task automatic t_lag();
    // R2: data present at the write edge itself must not be stored
    wr_data = 8'h3C;
    step();
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hE7;
    step();
    wr_en = 1'b0;
    exp_slot[1] = 8'h3C;
    check("R2 stores previous-edge data", cmp_val, pack_exp());
    // back-to-back writes: each stores the byte from one edge before
    wr_data = 8'h01;
    step();
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h02;
    step();
    wr_sel = 2'd3; wr_data = 8'h03;
    step();
    wr_en = 1'b0;
    exp_slot[0] = 8'h01; exp_slot[3] = 8'h02;
    check("R2 back-to-back writes", cmp_val, pack_exp());
  endtask

  task automatic t_disabled();
    wr_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      wr_sel = 2'(i); wr_data = 8'(8'h90 + i);
      step();
    end
    check("R4 no change with enable low", cmp_val, pack_exp());
  endtask

  task automatic t_replace();
    do_write(2'd2, 8'hFF);
    do_write(2'd2, 8'h00);
    check("R5 all ones to all zeros", cmp_val, pack_exp());
    do_write(2'd2, 8'hA5);
    do_write(2'd2, 8'h5A);
    check("R5 full bit flip", cmp_val, pack_exp());
  endtask

  task automatic t_edge();
    wr_data = 8'h6D;
    step();
    wr_en = 1'b1; wr_sel = 2'd0;
    @(posedge clk); #1;
    check("R7 no update on rising edge", cmp_val, pack_exp());
    step();
    wr_en = 1'b0;
    exp_slot[0] = 8'h6D;
    check("R7 update on falling edge", cmp_val, pack_exp());
  endtask

  task automatic t_match();
    for (int t = 0; t < 256; t++) begin
      tmr_lo = 8'(t); #1;
      check("R6 match sweep", {28'h0, match}, {28'h0, exp_match(8'(t))});
    end
    do_write(2'd1, 8'h6D);
    tmr_lo = 8'h6D; #1;
    check("R6 two slots equal value", {28'h0, match}, {28'h0, exp_match(8'h6D)});
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_select();
    t_lag();
    t_disabled();
    t_replace();
    t_edge();
    t_match();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule